// File: doc/BRIEF.md
# Time-Shared Layer Feedforward Neural Engine

This block evaluates a small fixed-point feedforward network while building only one physical layer. That layer has as many multiply-accumulate neurons as the widest layer of the network. A sequencer runs the same neurons once for each logical layer. In each pass every active neuron first takes its bias. It then sees one source value per cycle on a shared broadcast line and adds that value times its own weight. Weights and biases come from a computed coefficient ROM that is indexed by layer, neuron and source position.

When a layer's accumulation ends, the neurons hand their sums one per cycle to a single shared stage. That stage narrows the sum and applies a piecewise-linear sigmoid. Results of a hidden layer go into a buffer, which becomes the broadcast source for the next pass. Results of the final layer leave on a valid/ready stream. The external input values form the network's input layer and are passed unchanged into the first pass.

A one-cycle `start` pulse begins a run. Input samples are then taken on a valid/ready stream, and the outputs are returned on a valid/ready stream whose final beat carries `out_last`. Both streams follow the usual rules. A transfer happens on a cycle where valid and ready are both high. A producer holding valid keeps its data stable until the transfer. The engine raises `in_ready` only while it consumes input. It holds `out_data`/`out_last` steady while `out_ready` is low.

Top module: `lmx_engine`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `out_last` are low and the engine waits for `start`.
- R2: A run takes exactly `LAYER_SZ[0]` input transfers, in source order. While `in_valid` is low the engine waits with `in_ready` held high and does not advance.
- R3: Data, weights and biases are signed Q8.8. The net value of neuron n in computed layer l is bias b(l,n) plus the sum over source positions i of w(l,n,i) times source value i. The coefficients are w(l,n,i) = (((7l+5n+3i+1) mod 9) - 4) * 64 and b(l,n) = (((3l+5n+2) mod 7) - 3) * 32. The first computed layer (l=0) uses the raw input samples.
- R4: The net value is narrowed by an arithmetic right shift of 8 fractional bits, rounding toward minus infinity, and then saturated to the 16-bit signed range.
- R5: Activation on narrowed value x with m=|x| in Q8.8 gives p = 256 for m>=1280, (m>>5)+216 for 608<=m<1280, (m>>3)+160 for 256<=m<608, and (m>>2)+128 otherwise. The result is p for x>=0 and 256-p for x<0, so every output lies in 0..256.
- R6: Outputs leave in neuron order, one per transfer. `out_data` and `out_last` stay stable while `out_valid` is high and `out_ready` is low. `out_last` is high only on the final neuron of the output layer.
- R7: `start` has no effect while a run is in progress. After the last output transfer the engine is idle, with `in_ready` and `out_valid` low.
- R8: A layer narrower than the physical layer uses only its first neurons. A run therefore yields exactly `LAYER_SZ[NUM_LAYERS]` outputs.
- R9: Accumulation of a layer lasts exactly as many cycles as it has source values when no stall occurs. With `in_valid` held high, `in_ready` is high for exactly `LAYER_SZ[0]` cycles per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; ignored unless idle |
| in_data | input | DATA_W | Input sample, signed Q8.8 |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Engine accepts an input sample |
| out_data | output | DATA_W | Activated result, Q8.8 |
| out_valid | output | 1 | Output result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_last | output | 1 | Marks the final output of a run |

## Verification
The assertions assume the streams are well-behaved. `start` is pulsed only for a single cycle, and a producer never withdraws `in_valid` once it has raised it before the transfer. The stream bound also assumes that `in_data` is not counted outside a run. The bench keeps to these rules. It raises `in_valid` only at clock midpoints, holds it until the transfer is seen, and then drops it. It withholds `out_ready` on a fixed pattern, and it pulses `start` mid-run only as a single cycle. The value sweep covers a grid of inputs in which every breakpoint of the activation and both saturation limits appear at each input position.

// File: rtl/lmx_pkg.sv
package lmx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_BIAS,
    ST_ACCUM,
    ST_EMIT,
    ST_NEXT_LAYER,
    ST_DONE
  } lmx_state_e;

  // Coefficient generators: Q8.8 values in steps of 0.25 (weights) and 0.125 (biases)
  function automatic int lmx_weight(int layer, int neuron, int src);
    return (((layer * 7 + neuron * 5 + src * 3 + 1) % 9) - 4) * 64;
  endfunction

  function automatic int lmx_bias(int layer, int neuron);
    return (((layer * 3 + neuron * 5 + 2) % 7) - 3) * 32;
  endfunction

endpackage

// File: rtl/lmx_coef_rom.sv
module lmx_coef_rom #(
  parameter int DATA_W = 16,
  parameter int LW     = 1,
  parameter int IW     = 3,
  parameter int NEURON = 0
) (
  input  logic [LW-1:0]            layer,
  input  logic [IW-1:0]            idx,
  output logic signed [DATA_W-1:0] weight,
  output logic signed [DATA_W-1:0] bias
);
  import lmx_pkg::*;

  always_comb begin
    weight = DATA_W'(lmx_weight(int'(layer), NEURON, int'(idx)));
    bias   = DATA_W'(lmx_bias(int'(layer), NEURON));
  end

endmodule

// File: rtl/lmx_mac_neuron.sv
module lmx_mac_neuron #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int FRAC   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] bias,
  input  logic signed [DATA_W-1:0] x,
  input  logic signed [DATA_W-1:0] w,
  output logic signed [ACC_W-1:0]  acc
);

  logic signed [2*DATA_W-1:0] prod;
  logic signed [ACC_W-1:0]    prod_ext;
  logic signed [ACC_W-1:0]    bias_ext;

  assign prod     = x * w;
  assign prod_ext = ACC_W'(prod);
  assign bias_ext = ACC_W'(bias) <<< FRAC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (load) acc <= bias_ext;
    else if (en)   acc <= acc + prod_ext;
  end

  // R3: bias load and accumulation never coincide in one cycle
  assert_load_en_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !en);

endmodule

// File: rtl/lmx_pwl_act.sv
module lmx_pwl_act #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int FRAC   = 8
) (
  input  logic signed [ACC_W-1:0]  acc,
  output logic        [DATA_W-1:0] y
);

  localparam int ONE = 1 << FRAC;
  localparam logic signed [ACC_W-1:0] NET_HI = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NET_LO = -NET_HI - ACC_W'(1);
  localparam logic [DATA_W:0] K_ONE = (DATA_W+1)'(ONE);
  localparam logic [DATA_W:0] BP_1  = (DATA_W+1)'(ONE);
  localparam logic [DATA_W:0] BP_2  = (DATA_W+1)'((19 * ONE) / 8);
  localparam logic [DATA_W:0] BP_3  = (DATA_W+1)'(5 * ONE);
  localparam logic [DATA_W:0] OFS_A = (DATA_W+1)'(ONE / 2);
  localparam logic [DATA_W:0] OFS_B = (DATA_W+1)'((5 * ONE) / 8);
  localparam logic [DATA_W:0] OFS_C = (DATA_W+1)'((27 * ONE) / 32);

  logic signed [ACC_W-1:0]  shifted;
  logic signed [DATA_W-1:0] net;
  logic signed [DATA_W:0]   net_wide;
  logic        [DATA_W:0]   mag;
  logic        [DATA_W:0]   pos_y;
  logic        [DATA_W:0]   res;

  assign shifted  = acc >>> FRAC;

  always_comb begin
    if (shifted > NET_HI)      net = NET_HI[DATA_W-1:0];
    else if (shifted < NET_LO) net = NET_LO[DATA_W-1:0];
    else                       net = shifted[DATA_W-1:0];
  end

  assign net_wide = {net[DATA_W-1], net};
  assign mag      = net[DATA_W-1] ? $unsigned(-net_wide) : $unsigned(net_wide);

  always_comb begin
    if (mag >= BP_3)      pos_y = K_ONE;
    else if (mag >= BP_2) pos_y = (mag >> 5) + OFS_C;
    else if (mag >= BP_1) pos_y = (mag >> 3) + OFS_B;
    else                  pos_y = (mag >> 2) + OFS_A;
    res = net[DATA_W-1] ? (K_ONE - pos_y) : pos_y;
  end

  assign y = res[DATA_W-1:0];

endmodule

// File: rtl/lmx_engine.sv
module lmx_engine #(
  parameter int DATA_W     = 16,
  parameter int FRAC       = 8,
  parameter int ACC_W      = 40,
  parameter int NUM_LAYERS = 2,
  parameter int LAYER_SZ [NUM_LAYERS+1] = '{3, 4, 2}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last
);
  import lmx_pkg::*;

  function automatic int widest_layer();
    int m = 1;
    for (int k = 1; k <= NUM_LAYERS; k++) if (LAYER_SZ[k] > m) m = LAYER_SZ[k];
    return m;
  endfunction

  function automatic int widest_any();
    int m = widest_layer();
    if (LAYER_SZ[0] > m) m = LAYER_SZ[0];
    return m;
  endfunction

  localparam int MAX_N = widest_layer();
  localparam int IW    = $clog2(widest_any() + 1);
  localparam int BUF_D = 1 << IW;
  localparam int LW    = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1;
  localparam int ONE   = 1 << FRAC;

  lmx_state_e        state_q;
  logic [LW-1:0]     layer_q;
  logic [IW-1:0]     idx_q;
  logic [IW-1:0]     cur_src;
  logic [IW-1:0]     cur_dst;
  logic              last_layer;
  logic              last_dst;
  logic              beat;
  logic [DATA_W-1:0] buf_q [BUF_D];
  logic [DATA_W-1:0] x_bcast;
  logic [DATA_W-1:0] act_y;
  logic signed [ACC_W-1:0] acc_arr [BUF_D];
  logic [IW-1:0]     seen_q;

  // Layer geometry for the pass in progress
  always_comb begin
    cur_src = '0;
    cur_dst = '0;
    for (int k = 0; k < NUM_LAYERS; k++) begin
      if (LW'(k) == layer_q) begin
        cur_src = IW'(LAYER_SZ[k]);
        cur_dst = IW'(LAYER_SZ[k+1]);
      end
    end
  end

  assign last_layer = (layer_q == LW'(NUM_LAYERS - 1));
  assign last_dst   = (idx_q == cur_dst - IW'(1));
  assign in_ready   = (state_q == ST_ACCUM) && (layer_q == '0);
  assign beat       = (state_q == ST_ACCUM) && ((layer_q != '0) || in_valid);
  assign x_bcast    = (layer_q == '0) ? in_data : buf_q[idx_q];

  // Physical layer: one MAC neuron per slot of the widest layer
  for (genvar n = 0; n < BUF_D; n++) begin : g_slot
    if (n < MAX_N) begin : g_live
      logic signed [DATA_W-1:0] w_n;
      logic signed [DATA_W-1:0] b_n;
      logic                     act_n;

      assign act_n = (IW'(n) < cur_dst);

      lmx_coef_rom #(
        .DATA_W(DATA_W), .LW(LW), .IW(IW), .NEURON(n)
      ) u_rom (
        .layer (layer_q),
        .idx   (idx_q),
        .weight(w_n),
        .bias  (b_n)
      );

      lmx_mac_neuron #(
        .DATA_W(DATA_W), .ACC_W(ACC_W), .FRAC(FRAC)
      ) u_mac (
        .clk  (clk),
        .rst_n(rst_n),
        .load (state_q == ST_LOAD_BIAS),
        .en   (beat && act_n),
        .bias (act_n ? b_n : '0),
        .x    (x_bcast),
        .w    (w_n),
        .acc  (acc_arr[n])
      );
    end else begin : g_none
      assign acc_arr[n] = '0;
    end
  end

  // Single shared narrowing + activation stage
  lmx_pwl_act #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .FRAC(FRAC)
  ) u_act (
    .acc(acc_arr[idx_q]),
    .y  (act_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      layer_q   <= '0;
      idx_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      for (int k = 0; k < BUF_D; k++) buf_q[k] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_LOAD_BIAS;
            layer_q <= '0;
            idx_q   <= '0;
          end
        end
        ST_LOAD_BIAS: begin
          state_q <= ST_ACCUM;
          idx_q   <= '0;
        end
        ST_ACCUM: begin
          if (beat) begin
            if (idx_q == cur_src - IW'(1)) begin
              idx_q   <= '0;
              state_q <= ST_EMIT;
            end else begin
              idx_q <= idx_q + IW'(1);
            end
          end
        end
        ST_EMIT: begin
          if (!last_layer) begin
            buf_q[idx_q] <= act_y;
            if (last_dst) begin
              idx_q   <= '0;
              state_q <= ST_NEXT_LAYER;
            end else begin
              idx_q <= idx_q + IW'(1);
            end
          end else if (!out_valid || out_ready) begin
            out_data  <= act_y;
            out_valid <= 1'b1;
            out_last  <= last_dst;
            if (last_dst) begin
              idx_q   <= '0;
              state_q <= ST_DONE;
            end else begin
              idx_q <= idx_q + IW'(1);
            end
          end
        end
        ST_NEXT_LAYER: begin
          layer_q <= layer_q + LW'(1);
          state_q <= ST_LOAD_BIAS;
        end
        ST_DONE: begin
          if (!out_valid || out_ready) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Input transfers seen in the current run (assertion support)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              seen_q <= '0;
    else if (state_q == ST_IDLE && start)    seen_q <= '0;
    else if (in_valid && in_ready)           seen_q <= seen_q + IW'(1);
  end

  assert_in_accept_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (seen_q < IW'(LAYER_SZ[0])));

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_act_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_data) >= 0 && $signed(out_data) <= ONE));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q != ST_IDLE && state_q != ST_NEXT_LAYER) |=> (state_q != ST_LOAD_BIAS));

  assert_accum_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACCUM) |-> (idx_q < cur_src));

  assert_no_input_late_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

endmodule

// File: tb/lmx_engine_tb.sv
module lmx_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_last;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc++;

  lmx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last)
  );

  function automatic longint w_ref(int l, int n, int i);
    return longint'((((l * 7 + n * 5 + i * 3 + 1) % 9) - 4) * 64);
  endfunction

  function automatic longint b_ref(int l, int n);
    return longint'((((l * 3 + n * 5 + 2) % 7) - 3) * 32);
  endfunction

  function automatic longint act_ref(longint acc);
    longint x = acc >>> 8;
    longint m;
    longint p;
    if (x > 32767)  x = 32767;
    if (x < -32768) x = -32768;
    m = (x < 0) ? -x : x;
    if (m >= 1280)     p = 256;
    else if (m >= 608) p = (m >> 5) + 216;
    else if (m >= 256) p = (m >> 3) + 160;
    else               p = (m >> 2) + 128;
    return (x < 0) ? 256 - p : p;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vector(input int vec, input logic signed [15:0] a,
                            input logic signed [15:0] b, input logic signed [15:0] c);
    logic signed [15:0] xs [3];
    longint hid [4];
    longint expv [2];
    logic [15:0] got_d [2];
    logic        got_l [2];
    int in_gap = vec % 3;
    int stall  = vec % 2;
    int ready_cycles = 0;
    xs[0] = a; xs[1] = b; xs[2] = c;

    // Reference model (R3 R4 R5)
    for (int n = 0; n < 4; n++) begin
      longint s = b_ref(0, n) <<< 8;
      for (int i = 0; i < 3; i++) s += longint'(xs[i]) * w_ref(0, n, i);
      hid[n] = act_ref(s);
    end
    for (int n = 0; n < 2; n++) begin
      longint s = b_ref(1, n) <<< 8;
      for (int i = 0; i < 4; i++) s += hid[i] * w_ref(1, n, i);
      expv[n] = act_ref(s);
    end

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    fork
      begin : feed
        for (int k = 0; k < 3; k++) begin
          repeat (in_gap) @(negedge clk);
          in_data  = xs[k];
          in_valid = 1'b1;
          while (!in_ready) @(negedge clk);
          @(negedge clk);
          in_valid = 1'b0;
        end
      end
      begin : drain
        int got = 0;
        bit pend = 0;
        logic [15:0] held_d = '0;
        logic        held_l = 1'b0;
        while (got < 2) begin
          out_ready = (stall == 1 && (cyc % 4 == 0)) ? 1'b0 : 1'b1;
          if (in_ready) ready_cycles++;
          if (pend) begin
            check(out_valid && out_data == held_d && out_last == held_l,
                  "R6 hold under back-pressure", longint'(out_data), longint'(held_d));
          end
          pend = out_valid && !out_ready;
          held_d = out_data;
          held_l = out_last;
          if (out_valid && out_ready) begin
            got_d[got] = out_data;
            got_l[got] = out_last;
            got++;
          end
          @(negedge clk);
        end
        out_ready = 1'b1;
      end
      begin : late_start
        if (vec % 3 == 0) begin
          repeat (6) @(negedge clk);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join

    for (int n = 0; n < 2; n++) begin
      check(longint'(got_d[n]) == expv[n], "R3 R4 R5 output value",
            longint'(got_d[n]), expv[n]);
      check(got_l[n] == (n == 1), "R6 last flag", longint'(got_l[n]), longint'(n == 1));
    end
    if (in_gap == 0) begin
      check(ready_cycles == 3, "R9 accumulate cycles", ready_cycles, 3);
    end

    repeat (3) @(negedge clk);
    check(!out_valid, "R8 no extra outputs", longint'(out_valid), 0);
    check(!in_ready, "R7 idle after run", longint'(in_ready), 0);
  endtask

  logic signed [15:0] grid [NV];

  initial begin
    grid[0] = -16'sd32768; grid[1] = -16'sd1280; grid[2] = -16'sd608;
    grid[3] = -16'sd256;   grid[4] = -16'sd1;    grid[5] = 16'sd0;
    grid[6] = 16'sd1;      grid[7] = 16'sd256;   grid[8] = 16'sd608;
    grid[9] = 16'sd1280;   grid[10] = 16'sd32767;

    repeat (4) @(negedge clk);
    check(!in_ready && !out_valid && !out_last, "R1 reset state",
          longint'({in_ready, out_valid, out_last}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!in_ready && !out_valid, "R1 idle after reset",
          longint'({in_ready, out_valid}), 0);

    // R2: no input taken without start
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(!in_ready, "R2 no accept while idle", longint'(in_ready), 0);
    in_valid = 1'b0;

    for (int i = 0; i < NV; i++)
      for (int j = 0; j < NV; j++)
        for (int k = 0; k < NV; k++)
          run_vector(i * NV * NV + j * NV + k, grid[i], grid[j], grid[k]);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R2 R6 watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule